// File: doc/BRIEF.md
# Ethernet MAC Interrupt Combiner

This block gathers per-channel raw interrupt conditions from an Ethernet MAC and its management-interface controller and turns them into four system interrupt lines: receive threshold, receive, transmit and miscellaneous. Each class has its own enable mask. Software writes the mask and reads the masked status through a small register bus. Every output is a single-cycle pulse.

After a class pulses it stays quiet until software acknowledges it. Software does this by writing the class's end-of-interrupt code to one shared vector register. If conditions are still pending when the acknowledge arrives, the class pulses again. The receive and transmit classes are paced: they may only pulse while an external pacing block holds a permit input high, and they stay pending otherwise. The threshold and miscellaneous classes fire as soon as they become pending.

Top module: `emac_irq_combiner`

## Requirements
- R1: A synchronous active-low reset clears every enable mask to zero, drives all four interrupt outputs low and leaves all classes armed.
- R2: The enable masks are written and read back at bus address 0 (receive threshold), 1 (receive), 2 (transmit) and 3 (miscellaneous). Channel masks are 8 bits wide. The miscellaneous mask keeps only bits [3:0], and its upper bits read as zero. A mask changes only when its own address is written.
- R3: Reading address 4 plus the class code returns that class's raw inputs ANDed with its enable mask. Disabled raw bits never cause a pulse. The miscellaneous raw bits are: bit 0 statistics pending, bit 1 host error pending, bit 2 link change, bit 3 management user access.
- R4: The threshold and miscellaneous classes, when armed with a nonzero masked status at a clock edge, drive a one-cycle pulse in the following cycle whatever the permit input is.
- R5: The receive and transmit classes pulse only after an edge at which the permit input is high. While permit is low, a pending condition produces no pulse and stays pending until permit rises.
- R6: Once a class has pulsed it is disarmed. It produces no further pulse while its masked status stays nonzero, until it is acknowledged.
- R7: A bus write of value 0 (threshold), 1 (receive), 2 (transmit) or 3 (miscellaneous) to address 8 re-arms that class. If the class is still pending, it pulses again, subject to R5.
- R8: A write to address 8 with any value greater than 3 has no effect on any class.
- R9: An acknowledge given while a class has nothing pending re-arms it without a pulse. The next masked condition then produces exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pace_permit | input | 1 | High when the pacing block allows receive and transmit pulses |
| raw_thresh | input | 8 | Per-channel receive-threshold conditions |
| raw_rx | input | 8 | Per-channel receive conditions |
| raw_tx | input | 8 | Per-channel transmit conditions |
| raw_misc | input | 4 | Statistics, host error, link change, user access |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for read and write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_thresh | output | 1 | Receive-threshold interrupt pulse |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_tx | output | 1 | Transmit interrupt pulse |
| irq_misc | output | 1 | Miscellaneous interrupt pulse |

## Verification
The hardest states to reach are the ones where a class sits disarmed with its condition still asserted, because nothing at the outputs shows them. The stimulus holds a raw bit high across a pulse and then sends stray vector writes, valid acknowledges and permit toggles into that held state. The bench counts pulses in fixed windows after each of these events. A behavioural model also compares all four outputs on every clock, so a second pulse is caught even when it lands in a window where none is expected.

// File: rtl/irq_comb_pkg.sv
// Package: shared constants and class encoding for the interrupt combiner.
// Assumes four classes whose codes double as enable addresses and
// end-of-interrupt vector values.
package irq_comb_pkg;

    localparam int NUM_CLASSES = 4;
    localparam int CLS_W       = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_THRESH = 2'd0,
        CLS_RX     = 2'd1,
        CLS_TX     = 2'd2,
        CLS_MISC   = 2'd3
    } irq_class_e;

    // Register map word addresses
    localparam int EN_BASE   = 0;
    localparam int STAT_BASE = 4;
    localparam int EOI_ADDR  = 8;

    // Returns 1 for classes gated by the pacing permit
    function automatic bit class_is_paced(input int cls);
        return (cls == int'(CLS_RX)) || (cls == int'(CLS_TX));
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
// Module: enable-mask registers and end-of-interrupt decode.
// Holds one mask per class. The miscellaneous mask keeps only MISC_W bits.
// Decodes writes to the vector address into a one-hot acknowledge per class.
// Assumes bus writes are single-cycle strobes.
module irq_cfg_regs
    import irq_comb_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int MISC_W = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [NUM_CLASSES*CH_W-1:0]   en_flat,
    output logic [NUM_CLASSES-1:0]        eoi_hit
);

    localparam logic [ADDR_W-1:0] EOI_A    = ADDR_W'(EOI_ADDR);
    localparam logic [DATA_W-1:0] CLS_LIMIT = DATA_W'(NUM_CLASSES);

    logic eoi_valid;

    // Valid acknowledge: write to the vector address with an in-range code
    always_comb eoi_valid = bus_we && (bus_addr == EOI_A) && (bus_wdata < CLS_LIMIT);

    genvar c;
    generate
        for (c = 0; c < NUM_CLASSES; c++) begin : g_cls
            localparam int                KEEP_W = (c == int'(CLS_MISC)) ? MISC_W : CH_W;
            localparam logic [ADDR_W-1:0] MY_A   = ADDR_W'(EN_BASE + c);
            logic [CH_W-1:0] en_q;

            // Mask register: load on a write to this class's address
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q <= '0;
                end else if (bus_we && (bus_addr == MY_A)) begin
                    for (int b = 0; b < CH_W; b++) begin
                        en_q[b] <= (b < KEEP_W) ? bus_wdata[b] : 1'b0;
                    end
                end
            end

            // Acknowledge decode for this class
            always_comb eoi_hit[c] = eoi_valid && (bus_wdata[CLS_W-1:0] == CLS_W'(c));

            assign en_flat[c*CH_W +: CH_W] = en_q;
        end
    endgenerate

endmodule

// File: rtl/irq_class_unit.sv
// Module: arm/pulse controller for one interrupt class.
// Pulses for one cycle when armed and the masked status is nonzero. Paced
// instances also need the permit input high. It disarms on a pulse and
// re-arms on an acknowledge; if both happen in the same cycle, the
// acknowledge wins.
module irq_class_unit #(
    parameter int CH_W  = 8,
    parameter bit PACED = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] masked,
    input  logic            permit,
    input  logic            eoi,
    output logic            irq,
    output logic            armed
);

    logic pending;
    logic gate_ok;
    logic fire;

    // Pending when any enabled channel is set
    always_comb pending = |masked;

    // Paced variants honour the permit; immediate ones ignore it
    always_comb gate_ok = PACED ? permit : 1'b1;

    // Fire decision for this cycle
    always_comb fire = armed && pending && gate_ok;

    // Arm state: acknowledge re-arms, a pulse disarms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (eoi) begin
            armed <= 1'b1;
        end else if (fire) begin
            armed <= 1'b0;
        end
    end

    // Registered one-cycle output pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= fire;
        end
    end

endmodule

// File: rtl/irq_read_mux.sv
// Module: register read multiplexer.
// Returns the enable masks at their addresses, the masked status at the
// status addresses and zero elsewhere. Purely combinational.
module irq_read_mux
    import irq_comb_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [NUM_CLASSES*CH_W-1:0] en_flat,
    input  logic [NUM_CLASSES*CH_W-1:0] masked_flat,
    output logic [DATA_W-1:0]           bus_rdata
);

    // Address decode into mask or status words
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (bus_addr == ADDR_W'(EN_BASE + c)) begin
                bus_rdata = DATA_W'(en_flat[c*CH_W +: CH_W]);
            end
            if (bus_addr == ADDR_W'(STAT_BASE + c)) begin
                bus_rdata = DATA_W'(masked_flat[c*CH_W +: CH_W]);
            end
        end
    end

endmodule

// File: rtl/emac_irq_combiner.sv
// Module: top of the interrupt combiner.
// Masks the raw channel conditions per class and runs one class unit per
// class: paced for receive and transmit, immediate for threshold and
// miscellaneous. Raw inputs are assumed synchronous to clk.
module emac_irq_combiner
    import irq_comb_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int MISC_W = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pace_permit,
    input  logic [CH_W-1:0]   raw_thresh,
    input  logic [CH_W-1:0]   raw_rx,
    input  logic [CH_W-1:0]   raw_tx,
    input  logic [MISC_W-1:0] raw_misc,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_thresh,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_misc
);

    logic [NUM_CLASSES*CH_W-1:0] raw_flat;
    logic [NUM_CLASSES*CH_W-1:0] en_flat;
    logic [NUM_CLASSES*CH_W-1:0] masked_flat;
    logic [NUM_CLASSES-1:0]      eoi_hit;
    logic [NUM_CLASSES-1:0]      irq_vec;
    logic [NUM_CLASSES-1:0]      armed_vec;

    // Gather raw inputs into class order (code = slot)
    always_comb begin
        raw_flat = '0;
        raw_flat[int'(CLS_THRESH)*CH_W +: CH_W] = raw_thresh;
        raw_flat[int'(CLS_RX)*CH_W +: CH_W]     = raw_rx;
        raw_flat[int'(CLS_TX)*CH_W +: CH_W]     = raw_tx;
        raw_flat[int'(CLS_MISC)*CH_W +: MISC_W] = raw_misc;
    end

    // Apply the enable masks
    always_comb masked_flat = raw_flat & en_flat;

    irq_cfg_regs #(
        .CH_W(CH_W), .MISC_W(MISC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .en_flat(en_flat), .eoi_hit(eoi_hit)
    );

    irq_read_mux #(
        .CH_W(CH_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_rmux (
        .bus_addr(bus_addr), .en_flat(en_flat), .masked_flat(masked_flat),
        .bus_rdata(bus_rdata)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CLASSES; c++) begin : g_unit
            irq_class_unit #(
                .CH_W(CH_W), .PACED(class_is_paced(c))
            ) u_cls (
                .clk(clk), .rst_n(rst_n),
                .masked(masked_flat[c*CH_W +: CH_W]),
                .permit(pace_permit), .eoi(eoi_hit[c]),
                .irq(irq_vec[c]), .armed(armed_vec[c])
            );
        end
    endgenerate

    // Drive the named interrupt pins from class slots
    always_comb begin
        irq_thresh = irq_vec[int'(CLS_THRESH)];
        irq_rx     = irq_vec[int'(CLS_RX)];
        irq_tx     = irq_vec[int'(CLS_TX)];
        irq_misc   = irq_vec[int'(CLS_MISC)];
    end

endmodule

// File: rtl/irq_comb_checker.sv
// Module: assertion checker bound to the combiner top.
// Observes ports plus the mask, status and arm state of the top.
module irq_comb_checker
    import irq_comb_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          pace_permit,
    input logic                          bus_we,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [NUM_CLASSES-1:0]        irq_vec,
    input logic [NUM_CLASSES-1:0]        armed_vec,
    input logic [NUM_CLASSES*CH_W-1:0]   en_flat,
    input logic [NUM_CLASSES*CH_W-1:0]   masked_flat
);

    logic en_write;
    always_comb en_write = bus_we && (bus_addr < ADDR_W'(NUM_CLASSES));

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_vec == '0) && (en_flat == '0));

    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_write |=> $stable(en_flat));

    p_rx_needs_permit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vec[int'(CLS_RX)] |-> $past(pace_permit));

    p_tx_needs_permit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vec[int'(CLS_TX)] |-> $past(pace_permit));

    genvar c;
    generate
        for (c = 0; c < NUM_CLASSES; c++) begin : g_chk
            logic ack;
            logic bad_ack;
            always_comb ack = bus_we && (bus_addr == ADDR_W'(EOI_ADDR))
                              && (bus_wdata == DATA_W'(c));
            always_comb bad_ack = bus_we && (bus_addr == ADDR_W'(EOI_ADDR))
                                  && (bus_wdata >= DATA_W'(NUM_CLASSES));

            p_pulse_needs_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
                irq_vec[c] |-> $past(|masked_flat[c*CH_W +: CH_W]));

            p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
                irq_vec[c] && !$past(ack) |=> !irq_vec[c]);

            p_rearm_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ack |=> armed_vec[c]);

            p_bad_ack_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
                bad_ack && !armed_vec[c] |=> !armed_vec[c]);
        end
    endgenerate

endmodule

bind emac_irq_combiner irq_comb_checker #(
    .CH_W(CH_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pace_permit(pace_permit), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_vec(irq_vec),
    .armed_vec(armed_vec), .en_flat(en_flat), .masked_flat(masked_flat)
);

// File: tb/emac_irq_combiner_test.sv
`timescale 1ns/1ps
module emac_irq_combiner_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pace_permit = 1'b0;
    logic [7:0]  raw_thresh = '0, raw_rx = '0, raw_tx = '0;
    logic [3:0]  raw_misc = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_thresh, irq_rx, irq_tx, irq_misc;

    int checks = 0;
    int errors = 0;
    bit model_live = 1'b0;

    // Reference model state (class 0 thr, 1 rx, 2 tx, 3 misc)
    int m_en[4];
    bit m_armed[4];
    bit m_irq[4];

    always #5 clk = ~clk;

    emac_irq_combiner uut (
        .clk(clk), .rst_n(rst_n), .pace_permit(pace_permit),
        .raw_thresh(raw_thresh), .raw_rx(raw_rx), .raw_tx(raw_tx), .raw_misc(raw_misc),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_thresh(irq_thresh), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_misc(irq_misc)
    );

    function automatic int raw_of(int c);
        case (c)
            0: return int'(raw_thresh);
            1: return int'(raw_rx);
            2: return int'(raw_tx);
            default: return int'(raw_misc);
        endcase
    endfunction

    function automatic bit irq_of(int c);
        case (c)
            0: return irq_thresh;
            1: return irq_rx;
            2: return irq_tx;
            default: return irq_misc;
        endcase
    endfunction

    // Behavioural reference model, advanced at every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_en[c] = 0; m_armed[c] = 1'b1; m_irq[c] = 1'b0;
            end
        end else begin
            for (int c = 0; c < 4; c++) begin
                bit pend, fire, ack;
                pend = (raw_of(c) & m_en[c]) != 0;
                fire = m_armed[c] && pend && ((c == 0 || c == 3) || pace_permit);
                ack  = bus_we && bus_addr == 4'd8 && bus_wdata == 32'(c);
                m_irq[c] = fire;
                if (ack) m_armed[c] = 1'b1;
                else if (fire) m_armed[c] = 1'b0;
            end
            if (bus_we && bus_addr < 4'd4)
                m_en[bus_addr] = int'(bus_wdata[7:0]) & ((bus_addr == 4'd3) ? 'hF : 'hFF);
        end
        model_live = 1'b1;
    end

    // Per-cycle comparison against the model (R4 immediate, R5 paced)
    always @(negedge clk) begin
        if (model_live) begin
            for (int c = 0; c < 4; c++) begin
                checks++;
                if (irq_of(c) !== m_irq[c]) begin
                    errors++;
                    $display("FAIL %s class %0d irq: actual=%0b expected=%0b",
                             (c == 0 || c == 3) ? "R4" : "R5", c, irq_of(c), m_irq[c]);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read addr %0d: actual=%0h expected=%0h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic count_pulses(input int c, input int n, input int exp, input string tag);
        int got = 0;
        repeat (n) begin
            @(negedge clk);
            got += int'(irq_of(c));
        end
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s pulses class %0d: actual=%0d expected=%0d", tag, c, got, exp);
        end
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset, masks cleared
        rd(4'd0, 32'h0, "R1");
        rd(4'd1, 32'h0, "R1");
        count_pulses(0, 3, 0, "R1");

        // R2: program masks and read them back
        wr(4'd0, 32'h0F); wr(4'd1, 32'hFF); wr(4'd2, 32'hA5); wr(4'd3, 32'hFF);
        rd(4'd0, 32'h0F, "R2");
        rd(4'd2, 32'hA5, "R2");
        rd(4'd3, 32'h0F, "R2");

        // R4 then R6 on threshold class with condition held
        raw_thresh = 8'h01;
        count_pulses(0, 6, 1, "R4");
        count_pulses(0, 6, 0, "R6");

        // R8: out-of-range vector codes change nothing
        wr(4'd8, 32'd7); wr(4'd8, 32'd4);
        count_pulses(0, 6, 0, "R8");

        // R7: valid acknowledge with condition still present pulses again
        wr(4'd8, 32'd0);
        count_pulses(0, 6, 1, "R7");

        // R3: disabled channel only; status zero, no pulse after re-arm
        raw_thresh = 8'h10;
        rd(4'd4, 32'h0, "R3");
        wr(4'd8, 32'd0);
        count_pulses(0, 6, 0, "R3");

        // R9: armed with nothing pending, then a new condition pulses once
        raw_thresh = 8'h11;
        count_pulses(0, 6, 1, "R9");
        raw_thresh = 8'h00;

        // R4/R3: link-change bit (bit 2) fires misc with permit low
        raw_misc = 4'b0100;
        count_pulses(3, 6, 1, "R4");
        rd(4'd7, 32'h4, "R3");

        // R5: receive held pending while permit is low
        raw_rx = 8'h80;
        count_pulses(1, 8, 0, "R5");
        pace_permit = 1'b1;
        count_pulses(1, 6, 1, "R5");
        count_pulses(1, 4, 0, "R6");

        // R3: transmit raw bits all outside the mask
        raw_tx = 8'h5A;
        count_pulses(2, 6, 0, "R3");
        rd(4'd6, 32'h0, "R3");
        raw_tx = 8'h04;
        count_pulses(2, 6, 1, "R5");

        // R7: acknowledges for transmit and receive with conditions held
        wr(4'd8, 32'd2);
        count_pulses(2, 6, 1, "R7");
        wr(4'd8, 32'd1);
        count_pulses(1, 6, 1, "R7");

        // R5: re-armed receive waits for permit
        pace_permit = 1'b0;
        wr(4'd8, 32'd1);
        count_pulses(1, 6, 0, "R5");
        pace_permit = 1'b1;
        count_pulses(1, 6, 1, "R5");
        rd(4'd1, 32'hFF, "R2");

        // R1: reset mid-run clears masks
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(4'd1, 32'h0, "R1");
        rd(4'd3, 32'h0, "R1");
        count_pulses(1, 4, 0, "R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule